// File: doc/BRIEF.md
# Fan PWM Output Generator

This block drives a single fan control pin with a pulse-width waveform. Two byte-wide registers on a simple register bus control it. The fan register holds three things: a force-high bit, a 6-bit duty value, and one of the step-rate select bits. The fan-control register holds the other two step-rate bits, namely a rate-source bit and a rate-doubling bit. It also holds a 2-bit tachometer divisor code. The block stores that code and exports it as a decoded divisor value. It does not use the code itself.

Each PWM period lasts 64 steps. With a duty value D, the pin is high for the first D steps of the period and low for the rest. A counter advances one step on each pulse of a tick enable. That tick enable is picked from eight prescaled tick inputs by three register bits. A new duty value is held back until the current period ends, so the output never shows a shortened or split pulse.

Top module: `fan_pwm_gen`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - the fan register (address 0) reads 0x00;
  - the fan-control register (address 1) reads 0x10;
  - `fan_pin` is low;
  - `tach_div` is 2.
- R2: With the force bit clear, `fan_pin` is high for exactly D of any 64 consecutive step ticks. D is fan register bits 6:1.
  - D=0 never drives the pin high.
  - D=32 gives half duty.
  - D=63 gives 63 high steps and 1 low step.
- R3: When fan register bit 0 is 1, `fan_pin` is high from the cycle after that write, whatever the duty value and the ticks.
- R4: A new duty value takes effect only when the step counter wraps from 63 to 0. The remainder of the running period keeps the old duty value.
- R5: The step tick is `rate_tick[idx]`, where idx = {fan-control bit 2, fan register bit 7, fan-control bit 0}. Pulses on any other `rate_tick` bit do not advance the waveform. Bits 4..7 are meant to carry twice the rate of bits 0..3.
- R6: `tach_div` equals 1, 2, 4 or 8 for fan-control bits 5:4 equal to 00, 01, 10 or 11.
- R7: Fan-control bits 1, 3, 6 and 7 are reserved. They ignore writes and read 0. All eight fan register bits are writable and read back.
- R8: A write with `reg_wr` high updates the register at `reg_addr` on the next clock edge. `reg_rdata` shows the register at `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 fan, 1 fan-control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| rate_tick | input | 8 | Prescaled step tick enables, indexed by the rate select |
| fan_pin | output | 1 | PWM fan drive |
| tach_div | output | 4 | Decoded tachometer divisor (1, 2, 4, 8) |

## Verification
The hardest situation to reach is a duty write that lands in mid-period. The step counter cannot be seen at the ports, so the bench locates a period position from the pin itself. It waits for the falling edge of a 16-step pulse and writes a larger duty value at that moment. It then checks that the pin stays low for the rest of that period and takes the new width only after the wrap. For rate selection, each of the eight select codes is tested in turn. First only the selected tick bit is pulsed, and the pin must show the duty width. Then only the other seven bits are pulsed, and the pin must freeze.

// File: rtl/fan_pwm_pkg.sv
// Package: shared constants for the fan PWM generator.
// Assumes an 8-bit register bus with two registers selected by one address bit.
package fan_pwm_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned DUTY_W     = 6;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned NUM_TICKS  = 1 << SEL_W;
    localparam int unsigned DIV_W      = 4;

    localparam logic        ADDR_FAN   = 1'b0;
    localparam logic        ADDR_CTRL  = 1'b1;

    // Fan register field positions
    localparam int unsigned FAN_FORCE_BIT = 0;
    localparam int unsigned FAN_DUTY_LSB  = 1;
    localparam int unsigned FAN_CSEL_BIT  = 7;

    // Fan-control register field positions
    localparam int unsigned CTL_SRC_BIT   = 0;
    localparam int unsigned CTL_DBL_BIT   = 2;
    localparam int unsigned CTL_DIV_LSB   = 4;

    localparam logic [DATA_W-1:0] FAN_RESET  = 8'h00;
    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h10;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 8'h35;

    typedef struct packed {
        logic              force_hi;
        logic [DUTY_W-1:0] duty;
        logic [SEL_W-1:0]  rate_sel;
        logic [1:0]        div_code;
    } fan_cfg_t;
endpackage

// File: rtl/fan_pwm_regs.sv
// Module: fan_pwm_regs
// Holds the fan and fan-control registers, masks reserved bits, and returns
// read data for the addressed register. Assumes single-cycle write strobes.
module fan_pwm_regs
    import fan_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output fan_cfg_t          cfg
);
    logic [DATA_W-1:0] fan_q;
    logic [DATA_W-1:0] ctrl_q;

    // Register writes; reserved control bits are dropped on the way in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fan_q  <= FAN_RESET;
            ctrl_q <= CTRL_RESET;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_FAN)
                fan_q <= reg_wdata;
            else
                ctrl_q <= reg_wdata & CTRL_WMASK;
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = (reg_addr == ADDR_FAN) ? fan_q : ctrl_q;
    end

    // Field extraction into the configuration bundle
    always_comb begin
        cfg.force_hi = fan_q[FAN_FORCE_BIT];
        cfg.duty     = fan_q[FAN_DUTY_LSB +: DUTY_W];
        cfg.rate_sel = {ctrl_q[CTL_DBL_BIT], fan_q[FAN_CSEL_BIT], ctrl_q[CTL_SRC_BIT]};
        cfg.div_code = ctrl_q[CTL_DIV_LSB +: 2];
    end

    a_r8_fan_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_FAN) |=> (fan_q == $past(reg_wdata)));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL) |=> ((ctrl_q & ~CTRL_WMASK) == '0));
endmodule

// File: rtl/fan_pwm_ratesel.sv
// Module: fan_pwm_ratesel
// Picks the PWM step tick from the prescaled tick inputs and decodes the
// tachometer divisor. Assumes upper tick bits run at twice the lower rate.
module fan_pwm_ratesel
    import fan_pwm_pkg::*;
(
    input  logic [NUM_TICKS-1:0] rate_tick,
    input  logic [SEL_W-1:0]     rate_sel,
    input  logic [1:0]           div_code,
    output logic                 step_tick,
    output logic [DIV_W-1:0]     tach_div
);
    // Tick selection
    always_comb begin
        step_tick = rate_tick[rate_sel];
    end

    // One-hot divisor decode: bit i set for code i
    for (genvar i = 0; i < DIV_W; i++) begin : g_div
        assign tach_div[i] = (div_code == 2'(i));
    end
endmodule

// File: rtl/fan_pwm_core.sv
// Module: fan_pwm_core
// 64-step PWM: step counter, period-boundary duty latch and pin drive.
// Assumes step_tick is a single-cycle enable.
module fan_pwm_core
    import fan_pwm_pkg::*;
#(
    parameter int unsigned STEPS_W = DUTY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_tick,
    input  logic               force_hi,
    input  logic [STEPS_W-1:0] duty,
    output logic               fan_pin
);
    localparam logic [STEPS_W-1:0] CNT_MAX = {STEPS_W{1'b1}};

    logic [STEPS_W-1:0] cnt_q;
    logic [STEPS_W-1:0] duty_act_q;
    logic               wrap;

    assign wrap = step_tick && (cnt_q == CNT_MAX);

    // Step counter, advances only on the selected tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step_tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Active duty, refreshed only at the period wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_act_q <= '0;
        else if (wrap)
            duty_act_q <= duty;
    end

    // Pin drive: force overrides the comparator
    always_comb begin
        fan_pin = force_hi || (cnt_q < duty_act_q);
    end

    a_r4_duty_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_act_q));

    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(cnt_q));
endmodule

// File: rtl/fan_pwm_gen.sv
// Module: fan_pwm_gen (top)
// Fan PWM output generator: registers, rate selection and PWM core.
// Assumes rate_tick bits are prescaled enables synchronous to clk.
module fan_pwm_gen
    import fan_pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_TICKS-1:0] rate_tick,
    output logic                 fan_pin,
    output logic [DIV_W-1:0]     tach_div
);
    fan_cfg_t cfg;
    logic     step_tick;

    fan_pwm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    fan_pwm_ratesel u_rate (
        .rate_tick (rate_tick),
        .rate_sel  (cfg.rate_sel),
        .div_code  (cfg.div_code),
        .step_tick (step_tick),
        .tach_div  (tach_div)
    );

    fan_pwm_core #(.STEPS_W(DUTY_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .force_hi  (cfg.force_hi),
        .duty      (cfg.duty),
        .fan_pin   (fan_pin)
    );

    a_r3_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.force_hi |-> fan_pin);

    a_r6_div_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tach_div) == 1);
endmodule

// File: tb/test_fan_pwm_gen.sv
// Bench: directed scenarios for fan_pwm_gen, one task each, self-checking.
module test_fan_pwm_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] rate_tick = 8'h00;
    logic       fan_pin;
    logic [3:0] tach_div;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    fan_pwm_gen i_fan_pwm_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rate_tick (rate_tick),
        .fan_pin   (fan_pin),
        .tach_div  (tach_div)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wr_reg(input logic addr, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic addr, output logic [7:0] data);
        @(negedge clk);
        reg_addr = addr;
        #1 data = reg_rdata;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fan_pin) highs++;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(1'b0, v); check("R1 fan reg reset", v, 8'h00);
        rd_reg(1'b1, v); check("R1 ctrl reg reset", v, 8'h10);
        check("R1 pin low", fan_pin, 0);
        check("R1 tach divisor", tach_div, 2);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr_reg(1'b1, 8'hFF);
        rd_reg(1'b1, v); check("R7 reserved ctrl bits read 0", v, 8'h35);
        wr_reg(1'b0, 8'hA5);
        rd_reg(1'b0, v); check("R8 fan reg readback", v, 8'hA5);
        wr_reg(1'b1, 8'h10);
        wr_reg(1'b0, 8'h00);
    endtask

    task automatic t_duty(input int d);
        int h;
        rate_tick = 8'hFF;
        wr_reg(1'b0, 8'(d << 1));
        run(70);
        count_high(64, h);
        check($sformatf("R2 duty %0d high steps", d), h, d);
    endtask

    task automatic t_force;
        int h;
        rate_tick = 8'hFF;
        wr_reg(1'b0, 8'h01);
        @(negedge clk);
        check("R3 force high next cycle", fan_pin, 1);
        count_high(64, h);
        check("R3 force high whole period", h, 64);
        rate_tick = 8'h00;
        count_high(10, h);
        check("R3 force high without ticks", h, 10);
        rate_tick = 8'hFF;
        wr_reg(1'b0, 8'h00);
    endtask

    task automatic t_deferred;
        int  h;
        bit  prev;
        bit  found;
        rate_tick = 8'hFF;
        wr_reg(1'b0, 8'h20);   // duty 16
        run(70);
        found = 1'b0;
        prev  = fan_pin;
        for (int i = 0; i < 200 && !found; i++) begin
            @(negedge clk);
            if (prev && !fan_pin) found = 1'b1;
            prev = fan_pin;
        end
        check("R4 falling edge located", found, 1);
        wr_reg(1'b0, 8'h60);   // duty 48 written mid-period
        count_high(40, h);
        check("R4 old duty kept to period end", h, 0);
        run(30);
        count_high(64, h);
        check("R4 new duty after wrap", h, 48);
    endtask

    task automatic t_rate(input int idx);
        int  h;
        bit  ref_pin;
        int  changes;
        wr_reg(1'b1, 8'(8'h10 | ((idx >> 2) & 1) << 2 | (idx & 1)));
        wr_reg(1'b0, 8'(8'h40 | (((idx >> 1) & 1) << 7)));
        rate_tick = 8'(1 << idx);
        run(70);
        count_high(64, h);
        check($sformatf("R5 rate idx %0d selected tick drives PWM", idx), h, 32);
        rate_tick = ~8'(1 << idx);
        @(negedge clk);
        ref_pin = fan_pin;
        changes = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (fan_pin != ref_pin) changes++;
        end
        check($sformatf("R5 rate idx %0d other ticks ignored", idx), changes, 0);
    endtask

    task automatic t_tach;
        for (int c = 0; c < 4; c++) begin
            wr_reg(1'b1, 8'(c << 4));
            @(negedge clk);
            check($sformatf("R6 tach code %0d", c), tach_div, 1 << c);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_duty(0);
        t_duty(1);
        t_duty(32);
        t_duty(63);
        t_force();
        t_deferred();
        for (int k = 0; k < 8; k++) t_rate(k);
        t_tach();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule